// File: doc/BRIEF.md
# Shift, Swap and Decimal-Adjust Unit

This is a purely combinational operation unit that sits beside the accumulator datapath of an 8-bit microcontroller core. It takes one operand, a width select, an operation code and the current carry (CY) and auxiliary-carry (AC) flags. In the same cycle it returns a result and a new carry flag. Register-file access and instruction decoding stay with the surrounding core.

The three one-bit shifts work on a byte or on a 16-bit word. In every shift the bit that falls off the end goes into the carry. Two more operations always work on the low byte: a nibble exchange, and a decimal correction of the accumulator after a packed-BCD addition. The correction is steered by the incoming CY and AC flags. When a byte operation runs, the upper byte of the operand is passed to the result unchanged.

Top module: `shift_swap_da`

## Requirements
- R1: With `op_sel`=3'd0 (logical left shift), each bit n moves to n+1 and bit 0 becomes 0. `cy_out` takes the old top bit, which is bit 7 when `wide`=0 and bit 15 when `wide`=1.
- R2: With `op_sel`=3'd1 (arithmetic right shift), the top bit stays unchanged and each other bit n takes the old bit n+1. `cy_out` takes the old bit 0.
- R3: With `op_sel`=3'd2 (logical right shift), the top bit becomes 0 and each bit n takes the old bit n+1. `cy_out` takes the old bit 0.
- R4: In the shifts, `wide`=1 acts on all 16 bits. `wide`=0 acts on bits 7:0 only, and `result[15:8]` equals `opnd[15:8]`.
- R5: With `op_sel`=3'd3 (nibble swap), `result[7:4]`=`opnd[3:0]`, `result[3:0]`=`opnd[7:4]` and `result[15:8]`=`opnd[15:8]`. `cy_out` equals `cy_in`, and `wide` has no effect.
- R6: With `op_sel`=3'd4 (decimal adjust), 6 is first added to the low byte when its low nibble is greater than 9 or `ac_in`=1. A carry out of bit 7 from this step sets the carry.
- R7: In decimal adjust, 0x60 is then added when the high nibble of the partial result is greater than 9 or the carry is 1. The carry here is `cy_in` or the carry from the first step. A carry out of bit 7 sets `cy_out`.
- R8: Decimal adjust never clears the carry: `cy_in`=1 gives `cy_out`=1. It ignores `wide` and passes `opnd[15:8]` through.
- R9: The codes 3'd5, 3'd6 and 3'd7 are unassigned. They give `result`=`opnd` on all 16 bits and `cy_out`=`cy_in`.
- R10: The outputs follow the inputs within the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code (0 SLL, 1 SRA, 2 SRL, 3 swap, 4 decimal adjust) |
| wide | input | 1 | 1 selects a 16-bit shift, 0 selects a byte shift |
| opnd | input | 16 | Operand |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| result | output | 16 | Operation result |
| cy_out | output | 1 | New carry flag |

## Verification
The unit has no state, so any wrong decode or mis-wired bit shows at `result` or `cy_out` in the same cycle that the faulty input pattern is applied. The risky spots are the width-dependent top bit and the decimal correction. A wrong top bit gives a wrong carry or sign bit only for operands whose bit 7 and bit 15 differ. A wrong carry chain in the correction shows only when the low-nibble step carries out of bit 7 and so forces the high step. The bench therefore runs targeted operands for these cases and a wide sweep of random ones, and compares every cycle against a behavioural model.

// File: rtl/shift_swap_da.sv
module shift_swap_da #(
  parameter int WORD_W = 16
) (
  input  logic [2:0]        op_sel,
  input  logic              wide,
  input  logic [WORD_W-1:0] opnd,
  input  logic              cy_in,
  input  logic              ac_in,
  output logic [WORD_W-1:0] result,
  output logic              cy_out
);
  localparam int BYTE_W = WORD_W / 2;

  logic [BYTE_W-1:0] lo_b, hi_b;
  assign lo_b = opnd[BYTE_W-1:0];
  assign hi_b = opnd[WORD_W-1:BYTE_W];

  logic [BYTE_W:0] da_s1, da_s2;
  logic            da_c1, lo_fix, hi_fix;

  assign lo_fix = (lo_b[3:0] > 4'd9) || ac_in;
  assign da_s1  = {1'b0, lo_b} + (lo_fix ? (BYTE_W+1)'(6) : '0);
  assign da_c1  = da_s1[BYTE_W];
  assign hi_fix = (da_s1[7:4] > 4'd9) || cy_in || da_c1;
  assign da_s2  = {1'b0, da_s1[BYTE_W-1:0]} + (hi_fix ? (BYTE_W+1)'(8'h60) : '0);

  always_comb begin
    result = opnd;
    cy_out = cy_in;
    unique case (op_sel)
      3'd0: begin
        if (wide) begin
          result = {opnd[WORD_W-2:0], 1'b0};
          cy_out = opnd[WORD_W-1];
        end else begin
          result = {hi_b, lo_b[BYTE_W-2:0], 1'b0};
          cy_out = lo_b[BYTE_W-1];
        end
      end
      3'd1: begin
        cy_out = opnd[0];
        if (wide) result = {opnd[WORD_W-1], opnd[WORD_W-1:1]};
        else      result = {hi_b, lo_b[BYTE_W-1], lo_b[BYTE_W-1:1]};
      end
      3'd2: begin
        cy_out = opnd[0];
        if (wide) result = {1'b0, opnd[WORD_W-1:1]};
        else      result = {hi_b, 1'b0, lo_b[BYTE_W-1:1]};
      end
      3'd3: result = {hi_b, lo_b[3:0], lo_b[7:4]};
      3'd4: begin
        result = {hi_b, da_s2[BYTE_W-1:0]};
        cy_out = cy_in | da_c1 | da_s2[BYTE_W];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/shift_swap_da_chk.sv
module shift_swap_da_chk (
  input logic [2:0]  op_sel,
  input logic        wide,
  input logic [15:0] opnd,
  input logic        cy_in,
  input logic        ac_in,
  input logic [15:0] result,
  input logic        cy_out
);
  always_comb begin
    if (op_sel == 3'd0) begin
      assert_sll_fill_R1: assert (result[0] == 1'b0);
      assert_sll_carry_R1: assert (cy_out == (wide ? opnd[15] : opnd[7]));
    end
    if (op_sel == 3'd1) begin
      assert_sra_sign_R2: assert ((wide ? result[15] : result[7]) == (wide ? opnd[15] : opnd[7]));
      assert_sra_carry_R2: assert (cy_out == opnd[0]);
    end
    if (op_sel == 3'd2) begin
      assert_srl_top_R3: assert ((wide ? result[15] : result[7]) == 1'b0);
      assert_srl_carry_R3: assert (cy_out == opnd[0]);
    end
    if (op_sel <= 3'd2 && !wide)
      assert_byte_upper_R4: assert (result[15:8] == opnd[15:8]);
    if (op_sel == 3'd3) begin
      assert_swap_nibbles_R5: assert (result[3:0] == opnd[7:4] && result[7:4] == opnd[3:0]);
      assert_swap_carry_R5: assert (cy_out == cy_in);
    end
    if (op_sel == 3'd4 && cy_in)
      assert_da_keeps_carry_R8: assert (cy_out);
    if (op_sel == 3'd4)
      assert_da_upper_R8: assert (result[15:8] == opnd[15:8]);
    if (op_sel >= 3'd5)
      assert_passthru_R9: assert (result == opnd && cy_out == cy_in);
  end
endmodule

bind shift_swap_da shift_swap_da_chk u_chk (
  .op_sel(op_sel), .wide(wide), .opnd(opnd), .cy_in(cy_in), .ac_in(ac_in),
  .result(result), .cy_out(cy_out)
);

// File: tb/tb_shift_swap_da.sv
module tb_shift_swap_da;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [2:0]  op_sel;
  logic        wide, cy_in, ac_in;
  logic [15:0] opnd, result;
  logic        cy_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  shift_swap_da dut (.op_sel(op_sel), .wide(wide), .opnd(opnd), .cy_in(cy_in),
                     .ac_in(ac_in), .result(result), .cy_out(cy_out));

  function automatic void model(input int op, input int w, input int d, input int c,
                                input int a, output int r, output int co);
    int lo, hi, v;
    lo = d & 255; hi = d & 16'hFF00; r = d; co = c;
    case (op)
      0: if (w != 0) begin r = (d * 2) & 16'hFFFF; co = (d >> 15) & 1; end
         else begin r = hi | ((lo * 2) & 255); co = (lo >> 7) & 1; end
      1: begin co = d & 1;
           if (w != 0) r = (d / 2) | (d & 16'h8000);
           else r = hi | (lo / 2) | (lo & 8'h80); end
      2: begin co = d & 1;
           if (w != 0) r = d / 2; else r = hi | (lo / 2); end
      3: r = hi | ((lo % 16) * 16) | (lo / 16);
      4: begin
           v = lo;
           if ((v % 16) > 9 || a != 0) v = v + 6;
           if (v > 255) begin co = 1; v = v - 256; end
           if ((v / 16) > 9 || co != 0) v = v + 96;
           if (v > 255) begin co = 1; v = v - 256; end
           r = hi | v;
         end
      default: ;
    endcase
  endfunction

  function automatic string tag_of(input int op, input int w);
    case (op)
      0: return (w != 0) ? "R1" : "R1/R4";
      1: return (w != 0) ? "R2" : "R2/R4";
      2: return (w != 0) ? "R3" : "R3/R4";
      3: return "R5";
      4: return "R6/R7/R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input int op, input int w, input int d, input int c, input int a);
    int er, ec;
    @(posedge clk);
    #1;
    op_sel = 3'(op); wide = 1'(w); opnd = 16'(d); cy_in = 1'(c); ac_in = 1'(a);
    @(negedge clk);
    model(op, w, d, c, a, er, ec);
    checks++;
    if (result !== 16'(er) || cy_out !== 1'(ec)) begin
      errors++;
      $display("FAIL %s (R10 same cycle) op=%0d w=%0d d=%h cy=%0d ac=%0d: got %h/%0d expected %h/%0d",
               tag_of(op, w), op, w, d, c, a, result, cy_out, er, ec);
    end
  endtask

  initial begin
    op_sel = 3'd0; wide = 1'b0; opnd = 16'h0000; cy_in = 1'b0; ac_in = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (result !== 16'h0000 || cy_out !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state: got %h/%0d expected 0000/0", result, cy_out);
    end
    // R1 byte vs word top bit
    apply(0, 0, 16'h0080, 0, 0);
    apply(0, 1, 16'h0080, 0, 0);
    apply(0, 1, 16'h8001, 0, 0);
    // R2 sign kept at the selected width
    apply(1, 0, 16'h7F81, 0, 0);
    apply(1, 1, 16'h8081, 0, 0);
    // R3
    apply(2, 0, 16'hFFFF, 0, 0);
    apply(2, 1, 16'hFFFE, 1, 0);
    // R4 upper byte untouched in byte mode
    apply(0, 0, 16'hA5FF, 0, 0);
    // R5 swap ignores width, keeps carry
    apply(3, 1, 16'h12AB, 1, 1);
    apply(3, 0, 16'h0F0F, 0, 0);
    // R6/R7 decimal adjust corners
    apply(4, 0, 16'h009A, 0, 0);
    apply(4, 0, 16'h0099, 0, 1);
    apply(4, 0, 16'h00FA, 0, 0);
    apply(4, 0, 16'h0045, 0, 0);
    apply(4, 1, 16'h3312, 1, 0);
    apply(4, 0, 16'h00FF, 1, 1);
    // R9 unassigned codes
    apply(5, 1, 16'hBEEF, 1, 0);
    apply(6, 0, 16'h1234, 0, 1);
    apply(7, 1, 16'hFFFF, 0, 0);
    // R10 and all requirements: random sweep, compared every clock
    for (int i = 0; i < 4000; i++)
      apply($urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 65535),
            $urandom_range(0, 1), $urandom_range(0, 1));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule